// File: doc/BRIEF.md
# Latched Status-Change Interrupt Controller

This block collects interrupt sources for a line-interface status unit and reduces them to one shared, active-low interrupt line. A vector of status bits is sampled on every clock. A change in either direction on any bit latches a pending flag for that bit. Two elastic-buffer fault inputs, overflow and underflow, latch their own pending flags for as long as they stay high. Pending flags only take effect in host mode. In hardware mode the interrupt line stays released.

The host reads the pending flags and the clear/mask register at two addresses. One write sets the clear/mask register, and it does two jobs. A 1 masks its source. Once that source's condition has gone away, the same 1 also retires the pending flag. Writing 0 re-enables the source. The pad drives only low. It is modelled as an output enable plus a line-level view, so several devices can share the line with an external pull-up.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, every pending flag is 0, every clear/mask bit is 0, irq_oe_o is 0 and irq_n_o is 1.
- R2: In host mode, a rising or falling change of status bit k (bit k of stat_i) sets pending bit k at the next clock edge. Other pending bits are not affected.
- R3: In host mode, ovf_i high sets pending bit N_STAT at the next clock edge, and unf_i high sets pending bit N_STAT+1.
- R4: irq_oe_o is 1, and irq_n_o is 0, exactly when host mode is on and at least one pending bit has its clear/mask bit at 0. Otherwise irq_oe_o is 0 and irq_n_o is 1.
- R5: A pending bit clears at a clock edge when its clear/mask bit was 1 before that edge and its condition is absent at that edge. A status bit's condition is "no change this cycle"; a fault bit's condition is "input low". A pending bit never clears while its clear/mask bit is 0.
- R6: While a fault input stays high, its pending bit stays set even though its clear/mask bit is 1.
- R7: While a clear/mask bit is 1, its source does not assert the interrupt. This includes new events that arrive while the mask holds.
- R8: After 0 is written to a clear/mask bit, a new event on that source asserts the interrupt again.
- R9: With host_mode_i low, no pending bit is set and irq_oe_o stays 0.
- R10: Reads are combinational and have no side effects. With addr_i=0, rdata_o returns the pending flags. With addr_i=1, rdata_o returns the clear/mask register. A write (wr_en_i=1) stores wdata_i only when addr_i=1; a write with addr_i=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_mode_i | input | 1 | 1 = host (register) mode, 0 = hardware mode |
| stat_i | input | N_STAT | Status bits to watch for changes |
| ovf_i | input | 1 | Elastic-buffer overflow fault |
| unf_i | input | 1 | Elastic-buffer underflow fault |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = pending flags, 1 = clear/mask register |
| wdata_i | input | N_STAT+2 | Write data |
| rdata_o | output | N_STAT+2 | Read data |
| irq_n_o | output | 1 | Line level as seen with a pull-up (0 = asserted) |
| irq_oe_o | output | 1 | Pad drive enable; when 1 the pad drives 0 |

## Verification
Every source position is walked one at a time. Status bits get a rise and later a fall, which shows that both edges latch and that exactly one pending bit responds. Each event is repeated with the source unmasked, masked, and re-enabled. This separates the acknowledge role of a clear bit from its masking role. Faults are held high through a clear and then dropped, which tells level conditions apart from one-cycle change events. Hardware-mode stimulus and writes to the read-only address confirm that these paths leave the state untouched.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    ADDR_PEND = 1'b0,
    ADDR_CLR  = 1'b1
  } irq_addr_e;
endpackage

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] stat_i,
  output logic [WIDTH-1:0] chg_o
);
  logic [WIDTH-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_i;
  end

  assign chg_o = stat_i ^ stat_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cond_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  // set wins over clear; clear needs mask bit held and condition gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (en_i && cond_i)     pend_q <= 1'b1;
    else if (clr_i && !cond_i)   pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  p_set_on_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cond_i) |=> pend_q);
  p_no_clear_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);
  p_fault_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cond_i) |=> pend_q);
  p_hw_no_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_STAT = 8,
  localparam int unsigned SRC_W = N_STAT + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_mode_i,
  input  logic [N_STAT-1:0] stat_i,
  input  logic              ovf_i,
  input  logic              unf_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [SRC_W-1:0]  wdata_i,
  output logic [SRC_W-1:0]  rdata_o,
  output logic              irq_n_o,
  output logic              irq_oe_o
);
  logic [N_STAT-1:0] chg;
  logic [SRC_W-1:0]  cond;
  logic [SRC_W-1:0]  pend;
  logic [SRC_W-1:0]  clr_q;

  irq_chg_det #(.WIDTH(N_STAT)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_i),
    .chg_o  (chg)
  );

  // source order: status bits low, overflow, underflow on top
  assign cond = {unf_i, ovf_i, chg};

  for (genvar g = 0; g < SRC_W; g++) begin : g_src
    irq_src_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (host_mode_i),
      .cond_i (cond[g]),
      .clr_i  (clr_q[g]),
      .pend_o (pend[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   clr_q <= '0;
    else if (wr_en_i && irq_addr_e'(addr_i) == ADDR_CLR) clr_q <= wdata_i;
  end

  assign rdata_o  = (irq_addr_e'(addr_i) == ADDR_CLR) ? clr_q : pend;
  assign irq_oe_o = host_mode_i && |(pend & ~clr_q);
  assign irq_n_o  = ~irq_oe_o;

  p_irq_needs_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o |-> (host_mode_i && pend != '0));
  p_all_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&clr_q) |-> !irq_oe_o);
  p_pend_write_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i) |=> $stable(clr_q));
endmodule

// File: tb/tb_irq_latch_ctrl.sv
module tb_irq_latch_ctrl;
  localparam int N  = 8;
  localparam int SW = N + 2;

  logic clk = 1'b0, rst_n = 1'b0, host = 1'b1;
  logic [N-1:0]  stat = '0;
  logic ovf = 1'b0, unf = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic [SW-1:0] wdata = '0, rdata;
  logic irq_n, irq_oe;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_latch_ctrl #(.N_STAT(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .host_mode_i(host), .stat_i(stat),
    .ovf_i(ovf), .unf_i(unf), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n), .irq_oe_o(irq_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic a, output logic [SW-1:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr_clr(input logic [SW-1:0] v);
    @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = v;
    tick(); wr_en = 1'b0;
  endtask

  task automatic chk_irq(input string req, input logic exp);
    chk({req, " oe"}, 32'(irq_oe), 32'(exp));
    chk({req, " n"},  32'(irq_n),  32'(!exp));
  endtask

  logic [SW-1:0] v;

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(1'b0, v); chk("R1 pend", 32'(v), 0);
    rd(1'b1, v); chk("R1 clr", 32'(v), 0);
    chk_irq("R1", 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      logic [SW-1:0] b;
      b = SW'(1) << i;
      @(negedge clk); stat[i] = 1'b1; tick();
      rd(1'b0, v); chk("R2 rise", 32'(v), 32'(b));
      chk_irq("R4 rise", 1'b1);
      tick();
      rd(1'b0, v); chk("R5 unmasked stays", 32'(v), 32'(b));
      wr_clr(b);
      chk_irq("R7 mask", 1'b0);
      rd(1'b1, v); chk("R10 clr read", 32'(v), 32'(b));
      tick();
      rd(1'b0, v); chk("R5 cleared", 32'(v), 0);
      @(negedge clk); stat[i] = 1'b0; tick();
      rd(1'b0, v); chk("R2 fall", 32'(v), 32'(b));
      chk_irq("R7 masked event", 1'b0);
      tick();
      rd(1'b0, v); chk("R5 cleared fall", 32'(v), 0);
      wr_clr('0);
      @(negedge clk); stat[i] = 1'b1; tick();
      chk_irq("R8 reenabled", 1'b1);
      @(negedge clk); stat[i] = 1'b0; tick();
      wr_clr(b); tick();
      rd(1'b0, v); chk("R5 retire", 32'(v), 0);
      wr_clr('0);
    end

    for (int j = 0; j < 2; j++) begin
      logic [SW-1:0] b;
      b = SW'(1) << (N + j);
      @(negedge clk); if (j == 0) ovf = 1'b1; else unf = 1'b1;
      tick();
      rd(1'b0, v); chk("R3 fault set", 32'(v), 32'(b));
      chk_irq("R4 fault", 1'b1);
      wr_clr(b); tick(); tick();
      rd(1'b0, v); chk("R6 fault held", 32'(v), 32'(b));
      chk_irq("R7 fault masked", 1'b0);
      @(negedge clk); ovf = 1'b0; unf = 1'b0; tick();
      rd(1'b0, v); chk("R5 fault cleared", 32'(v), 0);
      wr_clr('0);
      chk_irq("R4 idle", 1'b0);
    end

    // R9 hardware mode
    @(negedge clk); host = 1'b0; stat = 8'hA5; ovf = 1'b1; unf = 1'b1; tick();
    rd(1'b0, v); chk("R9 no set", 32'(v), 0);
    chk_irq("R9", 1'b0);
    @(negedge clk); ovf = 1'b0; unf = 1'b0; tick();
    @(negedge clk); host = 1'b1; stat = 8'hA4; tick();
    rd(1'b0, v); chk("R2 single bit", 32'(v), 1);
    @(negedge clk); host = 1'b0; #1;
    chk_irq("R9 pending held", 1'b0);
    @(negedge clk); host = 1'b1; #1;
    chk_irq("R4 host back", 1'b1);

    // R10 write to pending address ignored, reads side-effect free
    @(negedge clk); wr_en = 1'b1; addr = 1'b0; wdata = '1; tick(); wr_en = 1'b0;
    rd(1'b1, v); chk("R10 ignored write", 32'(v), 0);
    rd(1'b0, v); chk("R10 pend kept", 32'(v), 1);
    rd(1'b0, v); chk("R10 read twice", 32'(v), 1);
    chk_irq("R10 irq kept", 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule